// File: doc/BRIEF.md
# Inbound Write Parity Error Reporter

This block sits beside the target side of a parallel PCI-style bus and checks every inbound write data phase for even parity. The lanes and byte enables of each phase are captured when the phase is valid, and the parity bit that arrives on the following clock completes the check. A failing phase never stalls the transfer. Phases are accepted for as long as the initiator keeps driving them and the queue-full input stays low.

Each failing phase has two results, and each is gated separately. If the response enable is set, the block drives an active-low error strobe for one clock. The strobe comes a fixed number of clocks after the bad phase, and that number depends on the bus mode. The error is logged in any case: a sticky detected-error bit is set, and a matching interrupt status bit is set when the interrupt mask allows it. In the ECC-capable PCI-X mode, the address and attributes of the first failing transaction are also captured. They stay held until software clears the capture-valid flag. Read data phases are never checked by this block.

Top module: `wr_parity_err_reporter`

## Requirements
- R1: `accept_o` equals `phase_vld_i & ~queue_full_i` in every cycle, whatever the parity results; a parity error never withdraws acceptance.
- R2: With `mode_i` = 2'b00 (conventional), a bad write phase in cycle P drives `perr_n_o` low in cycle P+2 only, for exactly one clock.
- R3: With `mode_i` = 2'b01, 2'b10 or 2'b11 (PCI-X), a bad write phase in cycle P drives `perr_n_o` low in cycle P+3 only, for exactly one clock.
- R4: `perr_n_o` is driven low only if `resp_en_i` was high in the cycle the parity bit was presented (P+1); status logging occurs whether or not it was.
- R5: A detected write parity error sets `det_perr_o` one clock after the parity cycle; the bit stays set until a write of `w1c_i[0]` = 1 clears it.
- R6: When an error is logged with `int_mask_i` low in the parity cycle, `int_perr_o` is set; with the mask high it is left unchanged; `w1c_i[1]` = 1 clears it.
- R7: If a clear (`w1c_i` bits 0/1/2) and a set of the same bit fall in the same cycle, the bit ends set.
- R8: Only in mode 2'b10, an error with `ecc_vld_o` low captures that phase's `addr_i`/`attr_i` into `ecc_addr_o`/`ecc_attr_o` and raises `ecc_vld_o`; later errors leave the capture unchanged until `w1c_i[2]` = 1 clears `ecc_vld_o`.
- R9: Data phases with `wr_i` = 0 (reads) cause no strobe and change no status or capture bit, whatever their parity.
- R10: In any cycle where `mode_i` differs from its value in the previous cycle, `perr_n_o` is high, and strobes still pending at that point are discarded.
- R11: During reset `perr_n_o` is high and `det_perr_o`, `int_perr_o` and `ecc_vld_o` are low.
- R12: A phase is in error when the XOR of `ad_i`, `be_i` (phase cycle) and `par_i` (next cycle) is 1; back-to-back bad phases give back-to-back low strobe cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | DATA_W (32) | Address/data lanes of the data phase |
| be_i | input | BE_W (4) | Byte enables of the data phase |
| par_i | input | 1 | Parity for the previous cycle's data phase |
| phase_vld_i | input | 1 | Data phase valid qualifier |
| wr_i | input | 1 | 1 = write phase, 0 = read phase |
| queue_full_i | input | 1 | Inbound queue cannot take more data |
| addr_i | input | ADDR_W (32) | Address of the current transaction |
| attr_i | input | ATTR_W (8) | Attributes of the current transaction |
| mode_i | input | 2 | 00 conventional, 01 PCI-X, 10 PCI-X with ECC capture, 11 PCI-X |
| resp_en_i | input | 1 | Parity error response enable |
| int_mask_i | input | 1 | Interrupt status mask (1 = masked) |
| w1c_i | input | 3 | Write-one-to-clear: bit0 status, bit1 interrupt status, bit2 capture valid |
| accept_o | output | 1 | Data phase accepted |
| perr_n_o | output | 1 | Active-low parity error strobe |
| det_perr_o | output | 1 | Sticky detected parity error status |
| int_perr_o | output | 1 | Interrupt status for detected parity error |
| ecc_vld_o | output | 1 | Capture registers hold a failing transaction |
| ecc_addr_o | output | ADDR_W (32) | Captured address |
| ecc_attr_o | output | ATTR_W (8) | Captured attributes |

## Verification
Clean bursts set against bursts with single, adjacent and spaced bad phases show whether the check really covers lanes, enables and the late parity bit, and whether adjacent errors merge or shift. The same single bad phase is repeated in each mode, with the enable off, with the mask set, and as a read. This separates the strobe delay from the gating of the strobe and from the gating of logging. Two errors in the capture mode with different addresses show whether the first capture holds. A mode switch made while a strobe is still in flight shows that the pending strobe is flushed.

// File: rtl/wpe_pkg.sv
package wpe_pkg;
   typedef enum logic [1:0] {
      MODE_CONV = 2'b00,
      MODE_PX   = 2'b01,
      MODE_PXE  = 2'b10,
      MODE_PXR  = 2'b11
   } bus_mode_e;

   localparam int CLR_W   = 3;
   localparam int CLR_DET = 0;
   localparam int CLR_INT = 1;
   localparam int CLR_ECC = 2;
endpackage

// File: rtl/wpe_parity_check.sv
module wpe_parity_check #(
   parameter int DATA_W = 32,
   parameter int BE_W   = 4,
   parameter int ADDR_W = 32,
   parameter int ATTR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              phase_vld_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] ad_i,
   input  logic [BE_W-1:0]   be_i,
   input  logic              par_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [ATTR_W-1:0] attr_i,
   output logic              err_o,
   output logic [ADDR_W-1:0] err_addr_o,
   output logic [ATTR_W-1:0] err_attr_o
);
   logic              wr_vld_q;
   logic              lane_x_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ATTR_W-1:0] attr_q;

   // stage 1: fold lanes and enables; parity arrives one clock later
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_vld_q <= 1'b0;
         lane_x_q <= 1'b0;
         addr_q   <= '0;
         attr_q   <= '0;
      end else begin
         wr_vld_q <= phase_vld_i & wr_i;
         if (phase_vld_i) begin
            lane_x_q <= ^{ad_i, be_i};
            addr_q   <= addr_i;
            attr_q   <= attr_i;
         end
      end
   end

   assign err_o      = wr_vld_q & (lane_x_q ^ par_i);
   assign err_addr_o = addr_q;
   assign err_attr_o = attr_q;

   p_err_from_write_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $past(phase_vld_i & wr_i));
endmodule

// File: rtl/wpe_strobe_delay.sv
module wpe_strobe_delay
   import wpe_pkg::*;
#(
   parameter int CONV_DLY = 2,
   parameter int PX_DLY   = 3
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      fire_i,
   input  bus_mode_e mode_i,
   output logic      perr_n_o
);
   localparam int TAPS     = PX_DLY - 1;
   localparam int CONV_TAP = CONV_DLY - 2;
   localparam int PX_TAP   = PX_DLY - 2;

   logic [TAPS-1:0] sh_q;
   bus_mode_e       mode_q;
   logic            chg;
   logic            tap;

   assign chg = (mode_i != mode_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_CONV;
      else        mode_q <= mode_i;
   end

   generate
      for (genvar g = 0; g < TAPS; g++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   sh_q[g] <= 1'b0;
            else if (chg) sh_q[g] <= 1'b0;
            else          sh_q[g] <= (g == 0) ? fire_i : sh_q[(g == 0) ? 0 : g-1];
         end
      end
   endgenerate

   assign tap      = (mode_i == MODE_CONV) ? sh_q[CONV_TAP] : sh_q[PX_TAP];
   assign perr_n_o = ~(tap & ~chg);

   p_quiet_on_switch_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i != $past(mode_i)) |-> perr_n_o);

   generate
      if (CONV_DLY == 2) begin : g_chk_conv
         p_conv_delay_r2 : assert property (@(posedge clk) disable iff (!rst_n)
            (fire_i && mode_i == MODE_CONV && !chg) |=>
               (!perr_n_o || mode_i != $past(mode_i)));
      end
      if (PX_DLY == 3) begin : g_chk_px
         p_px_delay_r3 : assert property (@(posedge clk) disable iff (!rst_n)
            ($past(fire_i, 2) && mode_i != MODE_CONV && $past(mode_i) == mode_i &&
             $past(mode_i, 2) == mode_i && $past(mode_i, 3) == mode_i) |-> !perr_n_o);
      end
   endgenerate
endmodule

// File: rtl/wpe_status_log.sv
module wpe_status_log
   import wpe_pkg::*;
#(
   parameter int  ADDR_W = 32,
   parameter int  ATTR_W = 8,
   parameter bit  ECC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              err_i,
   input  bus_mode_e         mode_i,
   input  logic              mask_i,
   input  logic [CLR_W-1:0]  clr_i,
   input  logic [ADDR_W-1:0] cap_addr_i,
   input  logic [ATTR_W-1:0] cap_attr_i,
   output logic              det_o,
   output logic              irq_o,
   output logic              ecc_vld_o,
   output logic [ADDR_W-1:0] ecc_addr_o,
   output logic [ATTR_W-1:0] ecc_attr_o
);
   logic det_q, irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         det_q <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         if (err_i)                 det_q <= 1'b1;
         else if (clr_i[CLR_DET])   det_q <= 1'b0;
         if (err_i && !mask_i)      irq_q <= 1'b1;
         else if (clr_i[CLR_INT])   irq_q <= 1'b0;
      end
   end

   assign det_o = det_q;
   assign irq_o = irq_q;

   generate
      if (ECC_EN) begin : g_ecc
         logic              vld_q;
         logic [ADDR_W-1:0] addr_q;
         logic [ATTR_W-1:0] attr_q;
         logic              take;

         assign take = err_i && (mode_i == MODE_PXE) && (!vld_q || clr_i[CLR_ECC]);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q  <= 1'b0;
               addr_q <= '0;
               attr_q <= '0;
            end else if (take) begin
               vld_q  <= 1'b1;
               addr_q <= cap_addr_i;
               attr_q <= cap_attr_i;
            end else if (clr_i[CLR_ECC]) begin
               vld_q  <= 1'b0;
            end
         end

         assign ecc_vld_o  = vld_q;
         assign ecc_addr_o = addr_q;
         assign ecc_attr_o = attr_q;

         p_first_capture_held_r8 : assert property (@(posedge clk) disable iff (!rst_n)
            (vld_q && !clr_i[CLR_ECC]) |=> ($stable(ecc_addr_o) && $stable(ecc_attr_o)));
      end else begin : g_no_ecc
         assign ecc_vld_o  = 1'b0;
         assign ecc_addr_o = '0;
         assign ecc_attr_o = '0;
      end
   endgenerate

   p_det_sticky_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      err_i |=> det_o);
   p_irq_set_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (err_i && !mask_i) |=> irq_o);
   p_irq_masked_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      ((!err_i || mask_i) && !clr_i[CLR_INT]) |=> $stable(irq_o));
endmodule

// File: rtl/wr_parity_err_reporter.sv
module wr_parity_err_reporter
   import wpe_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int BE_W     = 4,
   parameter int ADDR_W   = 32,
   parameter int ATTR_W   = 8,
   parameter int CONV_DLY = 2,
   parameter int PX_DLY   = 3,
   parameter bit ECC_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] ad_i,
   input  logic [BE_W-1:0]   be_i,
   input  logic              par_i,
   input  logic              phase_vld_i,
   input  logic              wr_i,
   input  logic              queue_full_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [ATTR_W-1:0] attr_i,
   input  logic [1:0]        mode_i,
   input  logic              resp_en_i,
   input  logic              int_mask_i,
   input  logic [2:0]        w1c_i,
   output logic              accept_o,
   output logic              perr_n_o,
   output logic              det_perr_o,
   output logic              int_perr_o,
   output logic              ecc_vld_o,
   output logic [ADDR_W-1:0] ecc_addr_o,
   output logic [ATTR_W-1:0] ecc_attr_o
);
   generate
      if (DATA_W < 1 || BE_W < 1 || ADDR_W < 1 || ATTR_W < 1) begin : g_bad_width
         $error("wr_parity_err_reporter: widths must be positive");
      end
      if (CONV_DLY < 2 || PX_DLY <= CONV_DLY) begin : g_bad_delay
         $error("wr_parity_err_reporter: need 2 <= CONV_DLY < PX_DLY");
      end
   endgenerate

   bus_mode_e         mode_e;
   logic              err;
   logic              fire;
   logic [ADDR_W-1:0] err_addr;
   logic [ATTR_W-1:0] err_attr;

   assign mode_e   = bus_mode_e'(mode_i);
   assign accept_o = phase_vld_i & ~queue_full_i;
   assign fire     = err & resp_en_i;

   wpe_parity_check #(
      .DATA_W (DATA_W), .BE_W (BE_W), .ADDR_W (ADDR_W), .ATTR_W (ATTR_W)
   ) u_check (
      .clk         (clk),
      .rst_n       (rst_n),
      .phase_vld_i (phase_vld_i),
      .wr_i        (wr_i),
      .ad_i        (ad_i),
      .be_i        (be_i),
      .par_i       (par_i),
      .addr_i      (addr_i),
      .attr_i      (attr_i),
      .err_o       (err),
      .err_addr_o  (err_addr),
      .err_attr_o  (err_attr)
   );

   wpe_strobe_delay #(
      .CONV_DLY (CONV_DLY), .PX_DLY (PX_DLY)
   ) u_strobe (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire_i   (fire),
      .mode_i   (mode_e),
      .perr_n_o (perr_n_o)
   );

   wpe_status_log #(
      .ADDR_W (ADDR_W), .ATTR_W (ATTR_W), .ECC_EN (ECC_EN)
   ) u_log (
      .clk        (clk),
      .rst_n      (rst_n),
      .err_i      (err),
      .mode_i     (mode_e),
      .mask_i     (int_mask_i),
      .clr_i      (w1c_i),
      .cap_addr_i (err_addr),
      .cap_attr_i (err_attr),
      .det_o      (det_perr_o),
      .irq_o      (int_perr_o),
      .ecc_vld_o  (ecc_vld_o),
      .ecc_addr_o (ecc_addr_o),
      .ecc_attr_o (ecc_attr_o)
   );

   p_accept_unblocked_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      (phase_vld_i && !queue_full_i) |-> accept_o);
   p_reset_quiet_r11 : assert property (@(posedge clk)
      !rst_n |-> (perr_n_o && !det_perr_o && !int_perr_o && !ecc_vld_o));
endmodule

// File: tb/wr_parity_err_reporter_test.sv
module wr_parity_err_reporter_test;
   localparam time CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ad_i = '0;
   logic [3:0]  be_i = '0;
   logic        par_i = 1'b0;
   logic        phase_vld_i = 1'b0;
   logic        wr_i = 1'b0;
   logic        queue_full_i = 1'b0;
   logic [31:0] addr_i = '0;
   logic [7:0]  attr_i = '0;
   logic [1:0]  mode_i = 2'b00;
   logic        resp_en_i = 1'b0;
   logic        int_mask_i = 1'b0;
   logic [2:0]  w1c_i = '0;
   logic        accept_o, perr_n_o, det_perr_o, int_perr_o, ecc_vld_o;
   logic [31:0] ecc_addr_o;
   logic [7:0]  ecc_attr_o;

   wr_parity_err_reporter uut (
      .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .be_i(be_i), .par_i(par_i),
      .phase_vld_i(phase_vld_i), .wr_i(wr_i), .queue_full_i(queue_full_i),
      .addr_i(addr_i), .attr_i(attr_i), .mode_i(mode_i), .resp_en_i(resp_en_i),
      .int_mask_i(int_mask_i), .w1c_i(w1c_i), .accept_o(accept_o),
      .perr_n_o(perr_n_o), .det_perr_o(det_perr_o), .int_perr_o(int_perr_o),
      .ecc_vld_o(ecc_vld_o), .ecc_addr_o(ecc_addr_o), .ecc_attr_o(ecc_attr_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int    n_chk = 0;
   int    n_err = 0;
   string cur_tag = "R11";

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   int          cyc = 0;
   int          pend[$];
   logic        m_pv, m_pw, m_e, m_chg, m_lo;
   logic [31:0] m_pad, m_paddr, m_ea;
   logic [3:0]  m_pbe;
   logic [7:0]  m_pattr, m_et;
   logic [1:0]  m_pmode;
   logic        m_det, m_irq, m_ev;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend.delete();
         m_pv = 0; m_pw = 0; m_pad = '0; m_pbe = '0; m_paddr = '0; m_pattr = '0;
         m_pmode = 2'b00; m_det = 0; m_irq = 0; m_ev = 0; m_ea = '0; m_et = '0;
      end else begin
         cyc++;
         m_chg = (mode_i != m_pmode);
         m_e   = m_pv && m_pw && ((^{m_pad, m_pbe}) ^ par_i);
         while (pend.size() > 0 && pend[0] < cyc) void'(pend.pop_front());
         if (m_chg) pend.delete();
         else if (m_e && resp_en_i) pend.push_back((mode_i == 2'b00) ? cyc : cyc + 1);
         if (m_e) m_det = 1; else if (w1c_i[0]) m_det = 0;
         if (m_e && !int_mask_i) m_irq = 1; else if (w1c_i[1]) m_irq = 0;
         if (m_e && mode_i == 2'b10 && (!m_ev || w1c_i[2])) begin
            m_ev = 1; m_ea = m_paddr; m_et = m_pattr;
         end else if (w1c_i[2]) m_ev = 0;
         m_pv = phase_vld_i; m_pw = wr_i; m_pad = ad_i; m_pbe = be_i;
         m_paddr = addr_i; m_pattr = attr_i; m_pmode = mode_i;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         m_lo = 0;
         foreach (pend[i]) if (pend[i] == cyc) m_lo = 1;
         if (mode_i != m_pmode) m_lo = 0;
         chk(cur_tag, "perr_n", perr_n_o, !m_lo);
         chk(cur_tag, "det", det_perr_o, m_det);
         chk(cur_tag, "int", int_perr_o, m_irq);
         chk(cur_tag, "ecc_vld", ecc_vld_o, m_ev);
         if (m_ev) chk(cur_tag, "ecc_cap", {ecc_attr_o, ecc_addr_o}, {m_et, m_ea});
         chk("R1", "accept", accept_o, phase_vld_i & ~queue_full_i);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic idle(input int k);
      repeat (k) tick();
   endtask

   task automatic pulse_clr(input logic [2:0] m);
      tick(); w1c_i = m; tick(); w1c_i = '0;
   endtask

   task automatic burst(input int n, input logic [7:0] bad, input logic wr,
                        input logic [31:0] a, input logic [7:0] t);
      logic [31:0] pad; logic [3:0] pbe; logic pbad; logic pv;
      pv = 0; pad = '0; pbe = '0; pbad = 0;
      for (int i = 0; i <= n; i++) begin
         tick();
         par_i = pv ? ((^{pad, pbe}) ^ pbad) : 1'b0;
         if (i < n) begin
            phase_vld_i = 1; wr_i = wr;
            ad_i = 32'h1357_9BDF * (i + 1) + a; be_i = 4'(15 - i);
            addr_i = a; attr_i = t;
            pad = ad_i; pbe = be_i; pbad = bad[i]; pv = 1;
         end else begin
            phase_vld_i = 0; wr_i = 0; pv = 0;
         end
      end
      tick();
      par_i = 0;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R11", "perr_n", perr_n_o, 1'b1);
      chk("R11", "det", det_perr_o, 1'b0);
      chk("R11", "int", int_perr_o, 1'b0);
      chk("R11", "ecc_vld", ecc_vld_o, 1'b0);
      tick(); rst_n = 1; resp_en_i = 1;

      cur_tag = "R12";
      burst(4, 8'h00, 1, 32'h1000_0000, 8'h11); idle(4);
      burst(5, 8'b0_0110, 1, 32'h1000_0100, 8'h12); idle(5);
      burst(4, 8'b1001, 1, 32'h1000_0200, 8'h13); idle(5);

      cur_tag = "R2";
      burst(1, 8'h1, 1, 32'h2000_0000, 8'h21); idle(5);

      cur_tag = "R10";
      tick(); mode_i = 2'b01; @(negedge clk);
      chk("R10", "perr_n switch", perr_n_o, 1'b1);
      idle(3);
      cur_tag = "R3";
      burst(2, 8'b01, 1, 32'h3000_0000, 8'h31); idle(5);
      mode_i = 2'b11; idle(3);
      burst(3, 8'b100, 1, 32'h3000_0100, 8'h32); idle(5);
      mode_i = 2'b01; idle(3);

      cur_tag = "R4";
      resp_en_i = 0; pulse_clr(3'b111);
      burst(1, 8'h1, 1, 32'h4000_0000, 8'h41); idle(5);
      @(negedge clk); chk("R4", "det logged without strobe", det_perr_o, 1'b1);
      resp_en_i = 1; tick();

      cur_tag = "R5";
      pulse_clr(3'b001); idle(1);
      @(negedge clk); chk("R5", "det cleared", det_perr_o, 1'b0);
      burst(1, 8'h1, 1, 32'h5000_0000, 8'h51); idle(8);
      @(negedge clk); chk("R5", "det sticky", det_perr_o, 1'b1);

      cur_tag = "R6";
      pulse_clr(3'b010); int_mask_i = 1;
      burst(2, 8'b11, 1, 32'h6000_0000, 8'h61); idle(4);
      @(negedge clk); chk("R6", "int masked", int_perr_o, 1'b0);
      int_mask_i = 0;
      burst(1, 8'h1, 1, 32'h6000_0100, 8'h62); idle(4);
      @(negedge clk); chk("R6", "int set", int_perr_o, 1'b1);

      cur_tag = "R7";
      tick(); phase_vld_i = 1; wr_i = 1; ad_i = 32'hA5A5_0001; be_i = 4'hF;
      addr_i = 32'h7000_0000; attr_i = 8'h71;
      tick(); phase_vld_i = 0; wr_i = 0; par_i = (^{32'hA5A5_0001, 4'hF}) ^ 1'b1;
      w1c_i = 3'b011;
      tick(); par_i = 0; w1c_i = '0; idle(3);
      @(negedge clk);
      chk("R7", "det set wins", det_perr_o, 1'b1);
      chk("R7", "int set wins", int_perr_o, 1'b1);

      cur_tag = "R8";
      tick(); mode_i = 2'b10; idle(3);
      pulse_clr(3'b100);
      burst(1, 8'h1, 1, 32'h8000_00A0, 8'h81); idle(4);
      burst(1, 8'h1, 1, 32'h8000_00B0, 8'h82); idle(4);
      @(negedge clk);
      chk("R8", "first capture held", ecc_addr_o, 32'h8000_00A0);
      chk("R8", "first attr held", ecc_attr_o, 8'h81);
      pulse_clr(3'b100); idle(1);
      @(negedge clk); chk("R8", "capture released", ecc_vld_o, 1'b0);
      burst(1, 8'h1, 1, 32'h8000_00C0, 8'h83); idle(4);
      @(negedge clk); chk("R8", "new capture", ecc_addr_o, 32'h8000_00C0);

      cur_tag = "R9";
      pulse_clr(3'b111);
      burst(3, 8'b111, 0, 32'h9000_0000, 8'h91); idle(5);
      @(negedge clk);
      chk("R9", "read det", det_perr_o, 1'b0);
      chk("R9", "read ecc", ecc_vld_o, 1'b0);

      cur_tag = "R1";
      queue_full_i = 1;
      burst(3, 8'b010, 1, 32'hA000_0000, 8'hA1);
      queue_full_i = 0;
      burst(3, 8'b010, 1, 32'hA000_0100, 8'hA2); idle(5);

      cur_tag = "R10";
      burst(1, 8'h1, 1, 32'hB000_0000, 8'hB1);
      mode_i = 2'b00; @(negedge clk);
      chk("R10", "switch cycle high", perr_n_o, 1'b1);
      tick(); @(negedge clk);
      chk("R10", "pending flushed", perr_n_o, 1'b1);
      idle(4);

      summary();
      $finish;
   end
endmodule